// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block paces one successive-approximation conversion in whole converter-clock cycles. It runs on the converter clock, and the host writes it through single-cycle strobes in that same clock domain. A start strobe sets a start bit. The conversion begins on the next rising edge. The block drives a sample-and-hold strobe and presents one trial code per cycle to an external comparator. Ten result bits are resolved from the MSB down. The finished value is written into a high and a low result register, and a sticky completion flag is raised.

A free-running option starts each new conversion directly after the previous one ends. The first conversion after reset, and the first after the block is disabled and enabled again, is a longer extended conversion.

The host writes the channel/reference selection into a buffer register. The select lines that drive the converter copy that buffer only while they are unlocked. They are locked while a conversion samples and steps, and they open again in the final cycle of the conversion.

The controller has four states:
- IDLE waits for the start bit and moves to SAMPLE.
- SAMPLE counts up to the hold cycle and moves to STEP.
- STEP resolves one bit per cycle and moves to DONE after the LSB.
- DONE is the final cycle. It returns to SAMPLE if the start bit is still set, and to IDLE otherwise.

Clearing the enable input forces IDLE from any state.

Top module: `adc_conv_seq`

## Requirements
- R1: A start strobe sampled at edge E0 begins the conversion at edge E1, and cycle 1 follows E1. A normal conversion lasts 13 cycles, and the completion flag reads 1 from cycle 13 onward.
- R2: In a normal conversion the hold strobe rises on the falling edge inside cycle 2 and falls on the falling edge inside cycle 3. It is high at no other time.
- R3: The first conversion after reset, or after enable returns high, is extended. Its hold strobe rises on the falling edge inside cycle 14, and its flag rises in cycle 25.
- R4: Each STEP cycle presents a trial code equal to the bits kept so far with the current bit set. The current bit is kept when cmp_in is 1 at the next rising edge. The order runs from bit 9 down to bit 0, so a comparator that reports trial <= v yields the result v.
- R5: At completion res_hi is loaded with result bits 9:8 and res_lo with bits 7:0. The two registers never change at any other time.
- R6: The completion flag stays at 1 until a cycle with flag_clr = 1. It reads 0 from the following cycle. If completion and flag_clr fall in the same cycle, completion wins.
- R7: In single mode (free_run = 0) the start bit, read on busy, clears in the completion cycle.
- R8: With free_run = 1, busy stays 1. Cycle 1 of the next conversion directly follows the completion cycle, with no idle cycle between them.
- R9: While no conversion runs, a write to the buffer with sel_wr appears on sel_applied two cycles after the strobe is driven.
- R10: sel_applied holds its value from cycle 1 to the completion cycle, even if the buffer is written during the conversion. A buffered value reaches sel_applied in the cycle after completion.
- R11: If enable is 0 at an edge, any conversion is aborted and the controller returns to IDLE. Busy clears, the flag and the results are left unchanged, and the next conversion is extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; 0 aborts and arms an extended conversion |
| start_wr | input | 1 | Strobe that sets the start bit (ignored while en = 0) |
| free_run | input | 1 | 1 = start again immediately after each completion |
| sel_wr | input | 1 | Write strobe for the selection buffer |
| sel_wdata | input | SEL_W | Value written into the selection buffer |
| flag_clr | input | 1 | Write-one strobe that clears the completion flag |
| cmp_in | input | 1 | Comparator result: 1 means keep the current trial bit |
| trial_code | output | RES_W | Trial code presented to the comparator during STEP, otherwise 0 |
| hold | output | 1 | Sample-and-hold strobe, changed on falling edges |
| sel_applied | output | SEL_W | Channel/reference lines driving the converter |
| busy | output | 1 | Start bit readback |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | RES_W-LO_W | Result MSBs |
| res_lo | output | LO_W | Result LSBs |

## Verification
All outputs are read 7 ns after a rising edge. A value written at a rising edge is therefore seen in the same cycle, and the hold strobe, which changes at a falling edge, is seen in the cycle whose falling edge set it. Cycle numbers count edges from the one that follows the start strobe's capture edge.
- Flag, results and busy are checked in cycle 13 (normal) or cycle 25 (extended).
- The hold strobe is checked in every cycle against cycle 2 or cycle 14.
- A buffer write is checked to reach the select lines two cycles after its strobe when idle, and in the cycle after completion when it arrives mid-conversion.
- An abort is checked one cycle after enable drops.

A near-exhaustive sweep converts every 10-bit input value. The expected result is the input itself, because the bench comparator reports trial <= v.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_STEP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int NORM_CYC = 13,
    parameter int EXT_CYC  = 25,
    localparam int CNT_W   = $clog2(EXT_CYC + 1),
    localparam int BIT_W   = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_bit,
    output seq_state_e       state,
    output logic [BIT_W-1:0] bit_idx,
    output logic             hold_now,
    output logic             finish
);
    localparam int NORM_HOLD = NORM_CYC - RES_W - 1;
    localparam int EXT_HOLD  = EXT_CYC - RES_W - 1;

    seq_state_e       state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [BIT_W-1:0] bit_n;
    logic             ext_cur, ext_cur_n;
    logic             ext_pend, ext_pend_n;
    logic [CNT_W-1:0] hold_cyc;

    assign hold_cyc = ext_cur ? CNT_W'(EXT_HOLD) : CNT_W'(NORM_HOLD);
    assign hold_now = (state == ST_SAMPLE) && (cnt == hold_cyc);
    assign finish   = en && (state == ST_STEP) && (bit_idx == '0);

    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        bit_n      = bit_idx;
        ext_cur_n  = ext_cur;
        ext_pend_n = ext_pend;
        if (!en) begin
            state_n    = ST_IDLE;
            cnt_n      = '0;
            ext_pend_n = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_bit) begin
                        state_n    = ST_SAMPLE;
                        cnt_n      = CNT_W'(1);
                        ext_cur_n  = ext_pend;
                        ext_pend_n = 1'b0;
                    end
                end
                ST_SAMPLE: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == hold_cyc) begin
                        state_n = ST_STEP;
                        bit_n   = BIT_W'(RES_W - 1);
                    end
                end
                ST_STEP: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (bit_idx == '0) state_n = ST_DONE;
                    else               bit_n   = bit_idx - BIT_W'(1);
                end
                ST_DONE: begin
                    if (start_bit) begin
                        state_n    = ST_SAMPLE;
                        cnt_n      = CNT_W'(1);
                        ext_cur_n  = ext_pend;
                        ext_pend_n = 1'b0;
                    end else begin
                        state_n = ST_IDLE;
                        cnt_n   = '0;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            ext_cur  <= 1'b0;
            ext_pend <= 1'b1;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            bit_idx  <= bit_n;
            ext_cur  <= ext_cur_n;
            ext_pend <= ext_pend_n;
        end
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W  = 10,
    localparam int BIT_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             finish,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);
    logic [RES_W-1:0] acc, acc_n, bit_mask;

    always_comb begin
        bit_mask = RES_W'(1) << bit_idx;
        acc_n    = (acc & ~bit_mask) | (cmp_in ? bit_mask : '0);
        trial    = step_en ? (acc | bit_mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            result <= '0;
        end else begin
            if (step_en) acc <= acc_n;
            else         acc <= '0;
            if (finish)  result <= acc_n;
        end
    end

endmodule

// File: rtl/adc_sel_buffer.sv
module adc_sel_buffer #(
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             unlock,
    output logic [SEL_W-1:0] applied
);
    logic [SEL_W-1:0] shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow  <= '0;
            applied <= '0;
        end else begin
            if (wr)     shadow  <= wdata;
            if (unlock) applied <= shadow;
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int LO_W     = 8,
    parameter int SEL_W    = 6,
    parameter int NORM_CYC = 13,
    parameter int EXT_CYC  = 25
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  start_wr,
    input  logic                  free_run,
    input  logic                  sel_wr,
    input  logic [SEL_W-1:0]      sel_wdata,
    input  logic                  flag_clr,
    input  logic                  cmp_in,
    output logic [RES_W-1:0]      trial_code,
    output logic                  hold,
    output logic [SEL_W-1:0]      sel_applied,
    output logic                  busy,
    output logic                  done_flag,
    output logic [RES_W-LO_W-1:0] res_hi,
    output logic [LO_W-1:0]       res_lo
);
    localparam int BIT_W = $clog2(RES_W);

    seq_state_e       fsm_state;
    logic [BIT_W-1:0] bit_idx;
    logic             hold_now, finish, step_en, unlock;
    logic             start_bit, flag_q, hold_q;
    logic [RES_W-1:0] result;

    adc_seq_fsm #(.RES_W(RES_W), .NORM_CYC(NORM_CYC), .EXT_CYC(EXT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .start_bit(start_bit),
        .state(fsm_state), .bit_idx(bit_idx), .hold_now(hold_now), .finish(finish)
    );

    assign step_en = (fsm_state == ST_STEP);
    assign unlock  = (fsm_state == ST_IDLE) || (fsm_state == ST_DONE);

    adc_sar_core #(.RES_W(RES_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .finish(finish),
        .bit_idx(bit_idx), .cmp_in(cmp_in), .trial(trial_code), .result(result)
    );

    adc_sel_buffer #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata),
        .unlock(unlock), .applied(sel_applied)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (!en)                        start_bit <= 1'b0;
            else if (start_wr)              start_bit <= 1'b1;
            else if (finish && !free_run)   start_bit <= 1'b0;
            if (finish)        flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_now;
    end

    assign hold      = hold_q;
    assign busy      = start_bit;
    assign done_flag = flag_q;
    assign res_hi    = result[RES_W-1:LO_W];
    assign res_lo    = result[LO_W-1:0];

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int SEL_W = 6,
    parameter int HI_W  = 2,
    parameter int LO_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             flag_clr,
    input logic             done_flag,
    input logic             busy,
    input logic             hold,
    input logic [SEL_W-1:0] sel_applied,
    input logic [HI_W-1:0]  res_hi,
    input logic [LO_W-1:0]  res_lo,
    input seq_state_e       state
);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    assert_disable_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!busy && state == ST_IDLE));

    assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE || state == ST_STEP) |=> $stable(sel_applied));

    assert_hold_in_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (state == ST_SAMPLE));

    assert_res_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({res_hi, res_lo}) |-> done_flag);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.SEL_W(SEL_W), .HI_W(RES_W - LO_W), .LO_W(LO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .flag_clr(flag_clr), .done_flag(done_flag),
    .busy(busy), .hold(hold), .sel_applied(sel_applied), .res_hi(res_hi),
    .res_lo(res_lo), .state(fsm_state)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1, start_wr = 1'b0, free_run = 1'b0, sel_wr = 1'b0, flag_clr = 1'b0;
    logic [5:0] sel_wdata = '0;
    logic [9:0] vin = '0;
    logic       cmp_in;
    logic [9:0] trial_code;
    logic       hold, busy, done_flag;
    logic [5:0] sel_applied;
    logic [1:0] res_hi;
    logic [7:0] res_lo;
    int         checks = 0, failures = 0;

    always #5 clk = ~clk;
    assign cmp_in = (trial_code <= vin);

    adc_conv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_wr(start_wr), .free_run(free_run),
        .sel_wr(sel_wr), .sel_wdata(sel_wdata), .flag_clr(flag_clr), .cmp_in(cmp_in),
        .trial_code(trial_code), .hold(hold), .sel_applied(sel_applied), .busy(busy),
        .done_flag(done_flag), .res_hi(res_hi), .res_lo(res_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #7;
    endtask

    task automatic run_conv(input logic [9:0] v, input bit ext, input bit fr, input bit do_start,
                            input bit sel_mid, input logic [5:0] sel_new);
        int hc   = ext ? 14 : 2;
        int last = ext ? 25 : 13;
        logic [5:0] sel_lock = '0;
        string tag = ext ? "R3" : "R2";
        vin = v;
        free_run = fr;
        if (do_start) begin
            tick; start_wr = 1'b1;
            tick; start_wr = 1'b0;
        end
        for (int c = 1; c <= last; c++) begin
            tick;
            chk(hold == (c == hc), tag, int'(hold), int'(c == hc));
            if (c == 1) sel_lock = sel_applied;
            chk(sel_applied == sel_lock, "R10", int'(sel_applied), int'(sel_lock));
            if (c >= 2 && c < last) chk(done_flag == 1'b0, "R1", int'(done_flag), 0);
            if (c == last) begin
                chk(done_flag == 1'b1, ext ? "R3" : "R1", int'(done_flag), 1);
                chk({res_hi, res_lo} == v, "R4", int'({res_hi, res_lo}), int'(v));
                chk(res_hi == v[9:8], "R5", int'(res_hi), int'(v[9:8]));
                chk(busy == fr, fr ? "R8" : "R7", int'(busy), int'(fr));
            end
            flag_clr = (c == 1);
            if (sel_mid) begin
                sel_wr    = (c == 5);
                sel_wdata = sel_new;
            end
        end
        sel_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #23 rst_n = 1'b1;
        tick;
        chk(done_flag == 0 && busy == 0 && hold == 0, "R1", int'(done_flag), 0);
        chk({res_hi, res_lo} == 0 && sel_applied == 0, "R5", int'({res_hi, res_lo}), 0);

        // R9: idle selection write reaches the lines two cycles after the strobe
        sel_wr = 1'b1; sel_wdata = 6'h15;
        tick; sel_wr = 1'b0;
        chk(sel_applied == 6'h00, "R9", int'(sel_applied), 0);
        tick;
        chk(sel_applied == 6'h15, "R9", int'(sel_applied), 'h15);

        // R3: first conversion after reset is extended
        run_conv(10'd777, 1'b1, 1'b0, 1'b1, 1'b0, 6'h0);

        // R6: flag persists while idle, then clears
        tick; tick; tick;
        chk(done_flag == 1'b1, "R6", int'(done_flag), 1);
        flag_clr = 1'b1; tick; flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R6", int'(done_flag), 0);

        // R4 R5: sweep every input value with normal conversions
        for (int v = 0; v < 1024; v++) run_conv(10'(v), 1'b0, 1'b0, 1'b1, 1'b0, 6'h0);

        // R10: write during a conversion is deferred to after completion
        run_conv(10'd300, 1'b0, 1'b0, 1'b1, 1'b1, 6'h2A);
        chk(sel_applied == 6'h15, "R10", int'(sel_applied), 'h15);
        tick;
        chk(sel_applied == 6'h2A, "R10", int'(sel_applied), 'h2A);

        // R8: free-running back-to-back, then leave free-run
        run_conv(10'd123, 1'b0, 1'b1, 1'b1, 1'b0, 6'h0);
        run_conv(10'd900, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0);
        tick;
        chk(hold == 1'b0 && busy == 1'b0, "R7", int'(busy), 0);

        // R11: abort in cycle 6, results and flag untouched, then extended
        flag_clr = 1'b1; tick; flag_clr = 1'b0;
        vin = 10'd55;
        tick; start_wr = 1'b1; tick; start_wr = 1'b0;
        for (int c = 1; c <= 6; c++) tick;
        en = 1'b0;
        tick;
        chk(busy == 1'b0, "R11", int'(busy), 0);
        chk(done_flag == 1'b0, "R11", int'(done_flag), 0);
        chk({res_hi, res_lo} == 10'd900, "R11", int'({res_hi, res_lo}), 900);
        start_wr = 1'b1; tick; start_wr = 1'b0;
        chk(busy == 1'b0, "R11", int'(busy), 0);
        en = 1'b1;
        run_conv(10'd641, 1'b1, 1'b0, 1'b1, 1'b0, 6'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule